// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is a bank of general-purpose pins that software reaches through a small memory-mapped register port. Each pin either drives an output level taken from a pattern register or acts as an interrupt source. An interrupt source detects a rising edge, a falling edge, a high level or a low level. Every pin has its own latched flag and mask bit, and the bank drives one combined interrupt line.

Each register group has three write addresses: a plain load, a set alias that ORs in the ones of the written word, and a clear alias that removes them. The same two pattern bits that choose the trigger of an interrupt pin also supply the output level of a plain output pin. Because the bank has no dual-edge trigger, software gets one by reading the synchronised pin level and moving the edge polarity to the opposite level each time it acknowledges.

Top module: `gpio_bank`

## Requirements
- R1: After reset every mask bit is 1, the select, both pattern and flag registers are 0, irqOut is 0 and pinOut is 0.
- R2: A read request on busRdEn returns data on busRdData one cycle later with busRdValid high. busAddr[7:4] picks the group: 0 pin level, 1 interrupt select, 2 mask, 3 pattern-1, 4 pattern-0, 5 flag. Any other group reads as 0, and busAddr[3:0] has no effect on reads.
- R3: For select, mask, pattern-1 and pattern-0, a write with busAddr[3:0]=0 loads the word. With 4 it sets the bits written as 1, and with 8 it clears them. Bits written as 0 keep their value, and any other low nibble leaves the register unchanged.
- R4: The pin-level group (0x00) is read-only and returns each pin input after a two-flop synchroniser.
- R5: When a pin's select bit is 0, pinOut for that pin equals its pattern-0 bit. When the select bit is 1, that pinOut bit is 0.
- R6: Trigger code {pattern-1, pattern-0} per pin means 11 rising edge, 10 falling edge, 01 high level, 00 low level. A flag is raised only on a pin whose select bit is 1.
- R7: An edge flag stays set until software writes 1 for that pin at the flag clear alias (0x58). Writes to 0x50 and 0x54 leave the flags unchanged.
- R8: In a level mode the flag is set again on every cycle the active level is present, so a clear does not hold while the level persists.
- R9: irqOut is a registered OR of flag AND NOT mask across all pins. It goes low one cycle after the last unmasked flag is cleared or masked.
- R10: Software can catch both edges of a pin by reading the level and then switching pattern-0 between the rising and falling codes after each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data, one bit per pin |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output level for pins not used as interrupt sources |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench first programs triggers on pins whose inputs already sit at a level, so that a design that flags on the current level rather than on a transition raises a false flag. It issues a flag clear while a level stays active and reads back at once. A design that lets the clear win over a fresh detection returns 0 there. The bench also samples irqOut in the cycle right after a clear, where it must still be high, and again one cycle later, which catches an interrupt that is unregistered or late. A full dual-edge round trip through polarity flips, plus writes to the flag's load and set addresses, exposes aliases decoded on the wrong register or wrong bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    WR_LOAD = 2'd0,
    WR_SET  = 2'd1,
    WR_CLR  = 2'd2,
    WR_NONE = 2'd3
  } wrOpE;

  typedef enum logic [2:0] {
    RS_LEVEL = 3'd0,
    RS_SEL   = 3'd1,
    RS_MASK  = 3'd2,
    RS_PAT1  = 3'd3,
    RS_PAT0  = 3'd4,
    RS_FLAG  = 3'd5,
    RS_NONE  = 3'd6
  } rdSrcE;

  typedef struct packed {
    logic  selWr;
    logic  maskWr;
    logic  pat1Wr;
    logic  pat0Wr;
    logic  flagClr;
    wrOpE  op;
    logic  rdEn;
    rdSrcE rdSrc;
  } ctrlStrobeT;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrobeT        strb
);

  localparam int unsigned GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  logic [3:0]       subAddr;
  wrOpE             op;

  assign grp     = busAddr[ADDR_W-1:4];
  assign subAddr = busAddr[3:0];

  always_comb begin
    unique case (subAddr)
      4'h0:    op = WR_LOAD;
      4'h4:    op = WR_SET;
      4'h8:    op = WR_CLR;
      default: op = WR_NONE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.op      = op;
    strb.rdEn    = busRdEn;
    strb.selWr   = busWrEn && (op != WR_NONE) && (grp == GRP_W'(1));
    strb.maskWr  = busWrEn && (op != WR_NONE) && (grp == GRP_W'(2));
    strb.pat1Wr  = busWrEn && (op != WR_NONE) && (grp == GRP_W'(3));
    strb.pat0Wr  = busWrEn && (op != WR_NONE) && (grp == GRP_W'(4));
    // only the clear alias touches the flags
    strb.flagClr = busWrEn && (op == WR_CLR) && (grp == GRP_W'(5));
    if (grp == GRP_W'(0))      strb.rdSrc = RS_LEVEL;
    else if (grp == GRP_W'(1)) strb.rdSrc = RS_SEL;
    else if (grp == GRP_W'(2)) strb.rdSrc = RS_MASK;
    else if (grp == GRP_W'(3)) strb.rdSrc = RS_PAT1;
    else if (grp == GRP_W'(4)) strb.rdSrc = RS_PAT0;
    else if (grp == GRP_W'(5)) strb.rdSrc = RS_FLAG;
    else                       strb.rdSrc = RS_NONE;
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strb,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [BUS_W-1:0]    rdData,
  output logic                rdValid,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] selQ,
  output logic [NUM_PINS-1:0] maskQ,
  output logic [NUM_PINS-1:0] flagQ
);

  function automatic logic [NUM_PINS-1:0] applyOp(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] din,
    input wrOpE                opSel
  );
    case (opSel)
      WR_LOAD: return din;
      WR_SET:  return cur | din;
      WR_CLR:  return cur & ~din;
      default: return cur;
    endcase
  endfunction

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncStg;
  logic [NUM_PINS-1:0] pat1Q, pat0Q, wrBits, pinNow, pinPrev, hit, clrBits;

  assign wrBits  = wrData[NUM_PINS-1:0];
  assign pinNow  = syncStg[SYNC_STAGES-1];
  assign clrBits = strb.flagClr ? wrBits : '0;

  // per-pin trigger decode and output level
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [1:0] mode;
    logic       rise, fall, lvl;
    assign mode      = {pat1Q[p], pat0Q[p]};
    assign rise      = pinNow[p] & ~pinPrev[p];
    assign fall      = ~pinNow[p] & pinPrev[p];
    assign lvl       = mode[0] ? pinNow[p] : ~pinNow[p];
    assign hit[p]    = selQ[p] & (mode[1] ? (mode[0] ? rise : fall) : lvl);
    assign pinOut[p] = ~selQ[p] & pat0Q[p];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncStg <= '0;
      pinPrev <= '0;
    end else begin
      syncStg <= {syncStg[SYNC_STAGES-2:0], pinIn};
      pinPrev <= pinNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      maskQ <= '1;
      pat1Q <= '0;
      pat0Q <= '0;
      flagQ <= '0;
    end else begin
      if (strb.selWr)  selQ  <= applyOp(selQ, wrBits, strb.op);
      if (strb.maskWr) maskQ <= applyOp(maskQ, wrBits, strb.op);
      if (strb.pat1Wr) pat1Q <= applyOp(pat1Q, wrBits, strb.op);
      if (strb.pat0Wr) pat0Q <= applyOp(pat0Q, wrBits, strb.op);
      // a detection in the same cycle outranks the software clear
      flagQ <= (flagQ & ~clrBits) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      irqOut  <= |(flagQ & ~maskQ);
      rdValid <= strb.rdEn;
      if (strb.rdEn) begin
        unique case (strb.rdSrc)
          RS_LEVEL: rdData <= BUS_W'(pinNow);
          RS_SEL:   rdData <= BUS_W'(selQ);
          RS_MASK:  rdData <= BUS_W'(maskQ);
          RS_PAT1:  rdData <= BUS_W'(pat1Q);
          RS_PAT0:  rdData <= BUS_W'(pat0Q);
          RS_FLAG:  rdData <= BUS_W'(flagQ);
          default:  rdData <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [BUS_W-1:0]    busWrData,
  input  logic                busRdEn,
  output logic [BUS_W-1:0]    busRdData,
  output logic                busRdValid,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                irqOut
);

  ctrlStrobeT          strb;
  logic [NUM_PINS-1:0] selQ, maskQ, flagQ;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .rdData  (busRdData),
    .rdValid (busRdValid),
    .pinOut  (pinOut),
    .irqOut  (irqOut),
    .selQ    (selQ),
    .maskQ   (maskQ),
    .flagQ   (flagQ)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [31:0]         busWrData,
  input logic                busRdEn,
  input logic                busRdValid,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] selQ,
  input logic [NUM_PINS-1:0] maskQ,
  input logic [NUM_PINS-1:0] flagQ
);

  logic [NUM_PINS-1:0] pend;
  logic                clrWr;
  assign pend  = flagQ & ~maskQ;
  assign clrWr = busWrEn && (busAddr == ADDR_W'(8'h58));

  a_r2_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  a_r2_rd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|pend) |=> irqOut);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(|pend) |=> !irqOut);
  a_r6_flag_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & ~$past(flagQ) & ~$past(selQ)) == '0));
  a_r7_flag_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagQ) & ~flagQ &
              ~($past(clrWr) ? $past(busWrData[NUM_PINS-1:0]) : '0)) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busWrData  (busWrData),
  .busRdEn    (busRdEn),
  .busRdValid (busRdValid),
  .irqOut     (irqOut),
  .selQ       (selQ),
  .maskQ      (maskQ),
  .flagQ      (flagQ)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .busRdValid(busRdValid), .pinIn(pinIn), .pinOut(pinOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // driver: issue a read and push what it must return
  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // monitor: compare returned read data against the queue
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        chk("R2 unexpected read data", busRdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, busRdData, e);
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 pinOut", pinOut, 32'h0);
    busRead(8'h20, 32'hFFFF_FFFF, "R1 mask");
    busRead(8'h10, 32'h0, "R1 sel");
    busRead(8'h30, 32'h0, "R1 pat1");
    busRead(8'h40, 32'h0, "R1 pat0");
    busRead(8'h50, 32'h0, "R1 flag");

    // R3 aliases on pattern-0, R5 output follows it
    busWrite(8'h40, 32'hA5A5_0F0F);
    busRead(8'h40, 32'hA5A5_0F0F, "R3 load");
    chk("R5 pinOut load", pinOut, 32'hA5A5_0F0F);
    busWrite(8'h44, 32'h0000_00F0);
    busRead(8'h40, 32'hA5A5_0FFF, "R3 set alias");
    busWrite(8'h48, 32'h0505_0000);
    busRead(8'h40, 32'hA0A0_0FFF, "R3 clear alias");
    busWrite(8'h4C, 32'hFFFF_FFFF);
    busRead(8'h4C, 32'hA0A0_0FFF, "R3 odd nibble ignored");
    chk("R5 pinOut after aliases", pinOut, 32'hA0A0_0FFF);
    busRead(8'h60, 32'h0, "R2 empty group");

    // R4 level read, read-only
    pinIn = 32'h0000_000A;
    cyc(4);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, 32'h0000_000A, "R4 level");

    // R6 configure pins 0..3: rising, falling, high, low
    busWrite(8'h30, 32'h0000_0003);
    busWrite(8'h40, 32'hA5A5_0005);
    busWrite(8'h10, 32'h0000_000F);
    chk("R5 pinOut selected pins zero", pinOut, 32'hA5A5_0000);
    cyc(4);
    busRead(8'h50, 32'h0, "R6 no false flags");
    busWrite(8'h28, 32'h0000_000F);
    busRead(8'h20, 32'hFFFF_FFF0, "R3 mask clear alias");

    // R6 rising edge on pin 0, R9 irq
    pinIn[0] = 1'b1;
    cyc(4);
    busRead(8'h50, 32'h1, "R6 rising flag");
    chk("R9 irq raised", {31'b0, irqOut}, 32'h1);
    busWrite(8'h58, 32'h1);
    chk("R9 irq still high one cycle", {31'b0, irqOut}, 32'h1);
    cyc(1);
    chk("R9 irq low after clear", {31'b0, irqOut}, 32'h0);
    pinIn[0] = 1'b0;
    cyc(4);
    busRead(8'h50, 32'h0, "R6 rising ignores fall");

    // R7 falling edge sticky, load/set aliases ignored
    pinIn[1] = 1'b0;
    cyc(4);
    busRead(8'h50, 32'h2, "R6 falling flag");
    cyc(6);
    busWrite(8'h50, 32'hFFFF_FFFF);
    busWrite(8'h54, 32'hFFFF_FFFF);
    busRead(8'h50, 32'h2, "R7 sticky, writes ignored");
    busWrite(8'h58, 32'h2);
    busRead(8'h50, 32'h0, "R7 cleared");

    // R8 high level keeps re-setting
    pinIn[2] = 1'b1;
    cyc(4);
    busWrite(8'h58, 32'h4);
    busRead(8'h50, 32'h4, "R8 level re-sets");
    pinIn[2] = 1'b0;
    cyc(4);
    busWrite(8'h58, 32'h4);
    busRead(8'h50, 32'h0, "R8 cleared after level gone");

    // R6 low level on pin 3, R9 masking
    pinIn[3] = 1'b0;
    cyc(4);
    busRead(8'h50, 32'h8, "R6 low flag");
    chk("R9 irq low-level", {31'b0, irqOut}, 32'h1);
    busWrite(8'h24, 32'h8);
    cyc(1);
    chk("R9 masked irq low", {31'b0, irqOut}, 32'h0);
    busRead(8'h50, 32'h8, "R9 masked flag kept");
    pinIn[3] = 1'b1;
    cyc(4);
    busWrite(8'h58, 32'h8);
    busRead(8'h50, 32'h0, "R8 low cleared");

    // R10 both-edge emulation on pin 0
    pinIn[0] = 1'b1;
    cyc(4);
    busRead(8'h50, 32'h1, "R10 first rise");
    busRead(8'h00, 32'h0000_0009, "R10 level high");
    busWrite(8'h48, 32'h1);
    busWrite(8'h58, 32'h1);
    busRead(8'h50, 32'h0, "R10 ack");
    pinIn[0] = 1'b0;
    cyc(4);
    busRead(8'h50, 32'h1, "R10 fall caught");
    busWrite(8'h44, 32'h1);
    busWrite(8'h58, 32'h1);
    busRead(8'h50, 32'h0, "R10 ack 2");
    pinIn[0] = 1'b1;
    cyc(4);
    busRead(8'h50, 32'h1, "R10 rise again");

    cyc(3);
    chk("R2 all reads returned", expQ.size(), 32'h0);
    finishRun();
  end

endmodule